// File: doc/BRIEF.md
# DRAM PHY Bring-up Phase Sequencer

This block is a small hardware controller that brings a DRAM PHY up in three separately started phases. The phases are impedance calibration, DRAM reset plus initialization, and a combined training pass that covers seven training steps. For each phase the controller forms one trigger word and writes it to the PHY control register. It then samples the PHY status word once per microsecond tick until every expected completion bit is set. Only after completion does it look at the error bits, and it reports the lowest-numbered failing step.

After a successful impedance calibration it waits one more tick, because the completion flag can rise before every ZQ block has finished. It then updates the ZQ control word in two writes: the first write forces a VT update, and the second write drops the force and turns on averaging. If the completion bits never all appear within the poll budget, the phase ends with a sticky timeout flag.

The tick is an input, so a bench or a faster clock domain can shorten the poll interval.

Top module: `phy_bringup_seq`

## Requirements
- R1: A start pulse seen while idle is accepted, and `trig_we` pulses in the following cycle. If several starts arrive together, impedance calibration wins over DRAM init, which wins over training. `busy` stays high until the phase ends. Starts seen while busy are ignored, so each phase gives exactly one trigger write.
- R2: Trigger word values. Bit 0 is always set. Impedance calibration gives 0x00000003 (bit 1). DRAM init gives 0x00000181 (bits 7 and 8). Training gives 0x0000FE01 (bits 9..15, one per step in step order). `trig_word` is zero when `trig_we` is low.
- R3: Expected completion masks. Bit 0 is always included. Impedance calibration uses 0x009 (bit 3). DRAM init uses 0x011 (bit 4). Training uses 0xFE1 (bits 5..11).
- R4: The status word is sampled only on a tick while polling. A phase completes on the first sampled word that holds every bit of its mask. Other status bits do not affect completion.
- R5: A phase whose mask has not been seen after POLL_LIMIT sampled polls ends with `timeout_flag` set and no done or error strobe. The flag stays set until the next accepted start clears it.
- R6: Error bits are examined only on the completing sample. Impedance calibration has error bit 20, reported as step 0. Training step k (0..6) has error bit 21+k. The lowest set step wins. `err_strobe` pulses for one cycle, and `err_step` holds the index until the next failure.
- R7: DRAM init has no error bit. It always ends in done once its mask is seen, whatever the error bits hold.
- R8: After impedance calibration succeeds, the block waits for one further tick and captures `zq_ctl_cur`. It then writes the captured word OR bit 27. In the next cycle it writes the captured word with bit 27 clear and bit 16 set. `done` follows in the cycle after that. Failed phases and other phases make no ZQ write.
- R9: `done` and `err_strobe` are one-cycle pulses, and `busy` is low in the cycle after either one. At most one of `trig_we`, `zq_we`, `done` and `err_strobe` is high in any cycle.
- R10: After reset, `busy`, all strobes, `timeout_flag` and `err_step` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle poll tick, nominally 1 us |
| start_zcal | input | 1 | Start impedance calibration phase |
| start_dinit | input | 1 | Start DRAM reset and init phase |
| start_train | input | 1 | Start combined training phase |
| phy_stat | input | 32 | PHY status word |
| zq_ctl_cur | input | 32 | Current ZQ control word |
| busy | output | 1 | A phase is in progress |
| trig_we | output | 1 | Write strobe for the trigger word |
| trig_word | output | 32 | Trigger word for the PHY control register |
| zq_we | output | 1 | Write strobe for the ZQ control word |
| zq_wdata | output | 32 | ZQ control word to write |
| done | output | 1 | Phase completed without error |
| err_strobe | output | 1 | Phase completed with a step error |
| err_step | output | 3 | Index of the first failing step |
| timeout_flag | output | 1 | Sticky poll timeout |

## Verification
The bound checker checks several properties on every cycle:
- the strobes never overlap;
- an idle start always yields a trigger in the next cycle, and that trigger carries the init bit;
- the force write is always followed by the average write and then by done;
- a phase end always drops `busy`;
- a timeout never coincides with a result strobe;
- a trigger never occurs with a stale timeout flag.

Other behaviour needs the bench's scenarios with chosen status words, compared against a behavioural model on every cycle:
- the exact trigger and mask values;
- the step priority among several error bits;
- that error bits are ignored before completion;
- the poll count at which a timeout fires;
- the captured ZQ values.

// File: rtl/physeq_pkg.sv
package physeq_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_TRAIN = 7;
  localparam int STEP_W    = $clog2(NUM_TRAIN);

  // trigger bit positions
  localparam int TRG_INIT   = 0;
  localparam int TRG_ZCAL   = 1;
  localparam int TRG_DRST   = 7;
  localparam int TRG_DINIT  = 8;
  localparam int TRG_TRAIN0 = 9;
  // status completion bit positions
  localparam int DN_INIT    = 0;
  localparam int DN_ZCAL    = 3;
  localparam int DN_DINIT   = 4;
  localparam int DN_TRAIN0  = 5;
  // status error bit positions
  localparam int ER_ZCAL    = 20;
  localparam int ER_TRAIN0  = 21;
  // ZQ control bits
  localparam int ZQ_FORCE   = 27;
  localparam int ZQ_AVG     = 16;

  typedef enum logic [1:0] {PH_ZCAL, PH_DINIT, PH_TRAIN} phase_e;

  typedef enum logic [2:0] {
    S_IDLE, S_TRIG, S_POLL, S_SETTLE, S_ZQF, S_ZQA, S_DONE, S_FAIL
  } seq_st_e;

  function automatic phase_e pick_phase(input logic z, input logic d);
    if (z)      return PH_ZCAL;
    else if (d) return PH_DINIT;
    else        return PH_TRAIN;
  endfunction

  function automatic logic [WORD_W-1:0] trigger_word(input phase_e ph);
    logic [WORD_W-1:0] w;
    w = '0;
    w[TRG_INIT] = 1'b1;
    case (ph)
      PH_ZCAL:  w[TRG_ZCAL] = 1'b1;
      PH_DINIT: begin w[TRG_DRST] = 1'b1; w[TRG_DINIT] = 1'b1; end
      PH_TRAIN: for (int k = 0; k < NUM_TRAIN; k++) w[TRG_TRAIN0 + k] = 1'b1;
      default:  ;
    endcase
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] done_mask(input phase_e ph);
    logic [WORD_W-1:0] m;
    m = '0;
    m[DN_INIT] = 1'b1;
    case (ph)
      PH_ZCAL:  m[DN_ZCAL] = 1'b1;
      PH_DINIT: m[DN_DINIT] = 1'b1;
      PH_TRAIN: for (int k = 0; k < NUM_TRAIN; k++) m[DN_TRAIN0 + k] = 1'b1;
      default:  ;
    endcase
    return m;
  endfunction

  function automatic logic [STEP_W-1:0] first_set(input logic [NUM_TRAIN-1:0] v);
    logic [STEP_W-1:0] idx;
    idx = '0;
    for (int k = NUM_TRAIN - 1; k >= 0; k--)
      if (v[k]) idx = STEP_W'(k);
    return idx;
  endfunction

  function automatic logic [WORD_W-1:0] zq_force_word(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    r[ZQ_FORCE] = 1'b1;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] zq_average_word(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    r[ZQ_FORCE] = 1'b0;
    r[ZQ_AVG]   = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/physeq_err_scan.sv
module physeq_err_scan
  import physeq_pkg::*;
(
  input  phase_e              phase,
  input  logic [WORD_W-1:0]   stat,
  output logic                hit,
  output logic [STEP_W-1:0]   idx
);
  logic [NUM_TRAIN-1:0] train_err;
  logic [NUM_TRAIN-1:0] cand;

  genvar k;
  generate
    for (k = 0; k < NUM_TRAIN; k++) begin : g_step
      assign train_err[k] = stat[ER_TRAIN0 + k];
    end
  endgenerate

  always_comb begin
    case (phase)
      PH_ZCAL:  cand = NUM_TRAIN'(stat[ER_ZCAL]);
      PH_TRAIN: cand = train_err;
      default:  cand = '0;
    endcase
  end

  assign hit = |cand;
  assign idx = first_set(cand);
endmodule

// File: rtl/physeq_poll_ctr.sv
module physeq_poll_ctr #(
  parameter int LIMIT = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic poll,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (poll)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import physeq_pkg::*;
#(
  parameter int POLL_LIMIT = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              start_zcal,
  input  logic              start_dinit,
  input  logic              start_train,
  input  logic [31:0]       phy_stat,
  input  logic [31:0]       zq_ctl_cur,
  output logic              busy,
  output logic              trig_we,
  output logic [31:0]       trig_word,
  output logic              zq_we,
  output logic [31:0]       zq_wdata,
  output logic              done,
  output logic              err_strobe,
  output logic [2:0]        err_step,
  output logic              timeout_flag
);
  seq_st_e             st;
  phase_e              phase;
  logic [STEP_W-1:0]   err_step_q;
  logic                tmo_q;
  logic [WORD_W-1:0]   zq_snap;

  // named internal events
  logic                start_any;
  logic                poll_fire;
  logic                all_set;
  logic                poll_last;
  logic                err_hit;
  logic [STEP_W-1:0]   err_idx;
  logic [WORD_W-1:0]   want_mask;

  assign start_any = start_zcal | start_dinit | start_train;
  assign poll_fire = (st == S_POLL) && tick_us;
  assign want_mask = done_mask(phase);
  assign all_set   = ((phy_stat & want_mask) == want_mask);

  physeq_err_scan u_scan (
    .phase (phase),
    .stat  (phy_stat),
    .hit   (err_hit),
    .idx   (err_idx)
  );

  physeq_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (st == S_TRIG),
    .poll  (poll_fire),
    .last  (poll_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      phase      <= PH_ZCAL;
      err_step_q <= '0;
      tmo_q      <= 1'b0;
      zq_snap    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_any) begin
          phase <= pick_phase(start_zcal, start_dinit);
          tmo_q <= 1'b0;
          st    <= S_TRIG;
        end
        S_TRIG: st <= S_POLL;
        S_POLL: if (poll_fire) begin
          if (all_set) begin
            if (err_hit) begin
              err_step_q <= err_idx;
              st         <= S_FAIL;
            end else if (phase == PH_ZCAL) begin
              st <= S_SETTLE;
            end else begin
              st <= S_DONE;
            end
          end else if (poll_last) begin
            tmo_q <= 1'b1;
            st    <= S_IDLE;
          end
        end
        S_SETTLE: if (tick_us) begin
          zq_snap <= zq_ctl_cur;
          st      <= S_ZQF;
        end
        S_ZQF:   st <= S_ZQA;
        S_ZQA:   st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy         = (st != S_IDLE);
  assign trig_we      = (st == S_TRIG);
  assign trig_word    = trig_we ? trigger_word(phase) : '0;
  assign zq_we        = (st == S_ZQF) || (st == S_ZQA);
  assign zq_wdata     = (st == S_ZQF) ? zq_force_word(zq_snap) :
                        (st == S_ZQA) ? zq_average_word(zq_snap) : '0;
  assign done         = (st == S_DONE);
  assign err_strobe   = (st == S_FAIL);
  assign err_step     = err_step_q;
  assign timeout_flag = tmo_q;
endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_any,
  input logic        busy,
  input logic        trig_we,
  input logic [31:0] trig_word,
  input logic        zq_we,
  input logic [31:0] zq_wdata,
  input logic        done,
  input logic        err_strobe,
  input logic [2:0]  err_step,
  input logic        timeout_flag
);
  p_start_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_any) |=> (trig_we && busy));

  p_trig_init_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_we |-> trig_word[0]);

  p_trig_clears_tmo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_we |-> !timeout_flag);

  p_tmo_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> (!busy && !done && !err_strobe));

  p_err_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_strobe |-> (err_step < 3'd7));

  p_zq_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (zq_we && zq_wdata[27]) |=> (zq_we && !zq_wdata[27] && zq_wdata[16]));

  p_zq_then_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (zq_we && !zq_wdata[27]) |=> done);

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trig_we, zq_we, done, err_strobe}));

  p_end_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err_strobe) |=> !busy);
endmodule

bind phy_bringup_seq phy_bringup_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_any    (start_any),
  .busy         (busy),
  .trig_we      (trig_we),
  .trig_word    (trig_word),
  .zq_we        (zq_we),
  .zq_wdata     (zq_wdata),
  .done         (done),
  .err_strobe   (err_strobe),
  .err_step     (err_step),
  .timeout_flag (timeout_flag)
);

// File: tb/phy_bringup_seq_tb.sv
`timescale 1ns/1ps
module phy_bringup_seq_tb;
  localparam int LIM = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_us = 1'b0;
  logic        start_zcal = 1'b0, start_dinit = 1'b0, start_train = 1'b0;
  logic [31:0] phy_stat = '0;
  logic [31:0] zq_ctl_cur = '0;
  logic        busy, trig_we, zq_we, done, err_strobe, timeout_flag;
  logic [31:0] trig_word, zq_wdata;
  logic [2:0]  err_step;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  phy_bringup_seq #(.POLL_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
    .start_zcal(start_zcal), .start_dinit(start_dinit), .start_train(start_train),
    .phy_stat(phy_stat), .zq_ctl_cur(zq_ctl_cur),
    .busy(busy), .trig_we(trig_we), .trig_word(trig_word),
    .zq_we(zq_we), .zq_wdata(zq_wdata), .done(done),
    .err_strobe(err_strobe), .err_step(err_step), .timeout_flag(timeout_flag)
  );

  // tick every third cycle
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 3;
    tick_us = (tcnt == 0);
  end

  // ---------------- behavioural reference ----------------
  // mode: 0 idle, 1 trigger, 2 polling, 3 settle, 4 force wr, 5 avg wr, 6 done, 7 fail
  int          m_mode = 0, m_ph = 0, m_polls = 0, m_err = 0;
  bit          m_tmo = 0;
  logic [31:0] m_snap = '0;

  function automatic logic [31:0] m_trig(int ph);
    case (ph) 0: return 32'h0000_0003; 1: return 32'h0000_0181; default: return 32'h0000_FE01; endcase
  endfunction
  function automatic logic [31:0] m_mask(int ph);
    case (ph) 0: return 32'h0000_0009; 1: return 32'h0000_0011; default: return 32'h0000_0FE1; endcase
  endfunction
  function automatic int m_first_err(int ph, logic [31:0] s);
    if (ph == 0) return s[20] ? 0 : -1;
    if (ph == 1) return -1;
    for (int k = 0; k < 7; k++) if (s[21 + k]) return k;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_ph = 0; m_polls = 0; m_err = 0; m_tmo = 0; m_snap = '0;
    end else begin
      case (m_mode)
        0: if (start_zcal || start_dinit || start_train) begin
             m_ph = start_zcal ? 0 : (start_dinit ? 1 : 2);
             m_tmo = 0; m_polls = 0; m_mode = 1;
           end
        1: m_mode = 2;
        2: if (tick_us) begin
             if ((phy_stat & m_mask(m_ph)) == m_mask(m_ph)) begin
               int e;
               e = m_first_err(m_ph, phy_stat);
               if (e >= 0) begin m_err = e; m_mode = 7; end
               else m_mode = (m_ph == 0) ? 3 : 6;
             end else if (m_polls + 1 == LIM) begin
               m_tmo = 1; m_mode = 0;
             end else m_polls++;
           end
        3: if (tick_us) begin m_snap = zq_ctl_cur; m_mode = 4; end
        4: m_mode = 5;
        5: m_mode = 6;
        default: m_mode = 0;
      endcase
    end
  end

  // per-cycle comparison plus event log
  int          n_trig = 0, n_done = 0, n_err = 0, n_zq = 0;
  logic [31:0] last_trig = '0;
  logic [31:0] zq_log [$];
  logic [2:0]  last_err = '0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [31:0] ezq;
      bit bad;
      bad = 0;
      ezq = (m_mode == 4) ? (m_snap | 32'h0800_0000) :
            (m_mode == 5) ? ((m_snap & ~32'h0800_0000) | 32'h0001_0000) : 32'h0;
      compared++;
      if (busy !== (m_mode != 0)) begin
        bad = 1; $display("FAIL R1 busy actual=%0b expected=%0b", busy, m_mode != 0);
      end
      if (trig_we !== (m_mode == 1) || trig_word !== ((m_mode == 1) ? m_trig(m_ph) : 32'h0)) begin
        bad = 1; $display("FAIL R2 trigger actual=%0b/%h expected=%0b/%h", trig_we, trig_word,
                          m_mode == 1, (m_mode == 1) ? m_trig(m_ph) : 32'h0);
      end
      if (zq_we !== (m_mode == 4 || m_mode == 5) || zq_wdata !== ezq) begin
        bad = 1; $display("FAIL R8 zq actual=%0b/%h expected=%0b/%h", zq_we, zq_wdata,
                          m_mode == 4 || m_mode == 5, ezq);
      end
      if (done !== (m_mode == 6)) begin
        bad = 1; $display("FAIL R9 done actual=%0b expected=%0b", done, m_mode == 6);
      end
      if (err_strobe !== (m_mode == 7) || err_step !== 3'(m_err)) begin
        bad = 1; $display("FAIL R6 err actual=%0b/%0d expected=%0b/%0d", err_strobe, err_step,
                          m_mode == 7, m_err);
      end
      if (timeout_flag !== m_tmo) begin
        bad = 1; $display("FAIL R5 timeout actual=%0b expected=%0b", timeout_flag, m_tmo);
      end
      if (bad) mismatched++;
      if (trig_we) begin n_trig++; last_trig = trig_word; end
      if (zq_we) begin n_zq++; zq_log.push_back(zq_wdata); end
      if (done) n_done++;
      if (err_strobe) begin n_err++; last_err = err_step; end
    end
  end

  // ---------------- scenario helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic go(input logic z, input logic d, input logic t);
    @(negedge clk);
    start_zcal = z; start_dinit = d; start_train = t;
    @(negedge clk);
    start_zcal = 0; start_dinit = 0; start_train = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int t0, d0, e0, z0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(busy === 0 && trig_we === 0 && zq_we === 0 && done === 0 && err_strobe === 0 &&
        timeout_flag === 0 && err_step === 0, "R10 reset outputs",
        {26'b0, busy, trig_we, zq_we, done, err_strobe, timeout_flag}, 32'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // zcal success with ZQ handshake
    zq_ctl_cur = 32'h0404_8900;
    phy_stat   = 32'h0000_0009;
    go(1, 0, 0);
    wait_idle();
    chk(last_trig == 32'h3, "R2 zcal trigger", last_trig, 32'h3);
    chk(zq_log.size() == 2, "R8 zq write count", zq_log.size(), 2);
    if (zq_log.size() == 2) begin
      chk(zq_log[0] == 32'h0C04_8900, "R8 force write", zq_log[0], 32'h0C04_8900);
      chk(zq_log[1] == 32'h0405_8900, "R8 average write", zq_log[1], 32'h0405_8900);
    end
    chk(n_done == 1, "R9 zcal done count", n_done, 1);

    // dinit with error bits present: still done
    phy_stat = 32'h0030_0011;
    go(0, 1, 0);
    wait_idle();
    chk(last_trig == 32'h181, "R2 dinit trigger", last_trig, 32'h181);
    chk(n_done == 2 && n_err == 0, "R7 dinit ignores errors", n_err, 0);

    // training: error bits before completion, then completion
    phy_stat = 32'h0480_0000;   // steps 2 and 5 flagged
    go(0, 0, 1);
    repeat (15) @(negedge clk);
    chk(busy === 1 && n_err == 0, "R6 errors not checked early", n_err, 0);
    phy_stat = 32'h0480_0FE1 | 32'h0000_F000; // extra unrelated bits (R4)
    wait_idle();
    chk(last_trig == 32'hFE01, "R2 train trigger", last_trig, 32'hFE01);
    chk(n_err == 1 && last_err == 3'd2, "R6 first failing step", last_err, 2);

    // zcal error: step 0, no ZQ writes
    z0 = n_zq;
    phy_stat = 32'h0010_0009;
    go(1, 0, 0);
    wait_idle();
    chk(n_err == 2 && last_err == 3'd0, "R6 zcal error step", last_err, 0);
    chk(n_zq == z0, "R8 no zq write after failure", n_zq, z0);

    // training timeout: one done bit missing, unrelated bits set (R3, R4, R5)
    d0 = n_done; e0 = n_err;
    phy_stat = 32'h8000_0EE3;
    go(0, 0, 1);
    wait_idle();
    chk(timeout_flag === 1, "R5 timeout set", timeout_flag, 1);
    chk(n_done == d0 && n_err == e0, "R5 no result strobe on timeout", n_done, d0);
    repeat (6) @(negedge clk);
    chk(timeout_flag === 1, "R5 timeout sticky", timeout_flag, 1);
    phy_stat = 32'h0000_0011;
    go(0, 1, 0);
    chk(timeout_flag === 0, "R5 new start clears timeout", timeout_flag, 0);
    wait_idle();
    chk(n_done == d0 + 1, "R5 phase after timeout completes", n_done, d0 + 1);

    // simultaneous starts and start while busy (R1)
    t0 = n_trig;
    phy_stat = 32'h0;
    go(1, 1, 1);
    repeat (5) @(negedge clk);
    go(0, 0, 1);
    phy_stat = 32'h0000_0009;
    wait_idle();
    chk(last_trig == 32'h3, "R1 zcal wins priority", last_trig, 32'h3);
    chk(n_trig == t0 + 1, "R1 start while busy ignored", n_trig, t0 + 1);

    // dinit over training priority
    phy_stat = 32'h0000_0011;
    go(0, 1, 1);
    wait_idle();
    chk(last_trig == 32'h181, "R1 dinit over training", last_trig, 32'h181);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule